// File: doc/BRIEF.md
# Runtime-Configurable Asynchronous Serial Engine

This block is a full-duplex asynchronous serial link engine. Its transmit half turns a byte handed over on a strobe into a serial frame on `txd`. Its receive half watches `rxd`, rebuilds incoming frames and offers each byte to an internal consumer, which must acknowledge it. Three inputs fix the frame shape: the number of system clocks per serial bit, the number of data bits and the number of stop bits. They are live inputs, not build-time constants, and a frame already under way always finishes with the values it captured at its start.

A value of zero on any of the configuration inputs selects the built-in default: 288 clocks per bit, a full byte of data, one stop bit. The engine therefore runs correctly out of reset even when the configuration inputs are tied low. A loopback control routes the transmitter's own serial output into the receiver, so the link can be tested without external wiring.

Top module: `uart_engine`

## Requirements
- R1: While `rst_n` is low at a clock edge (synchronous, active low), the next cycle shows `txd` high, `tx_ready` high, `rx_valid` low and `rx_overrun` low.
- R2: A transmitted frame is one low start bit, then the data bits least significant first, then the stop bits driven high. Every bit lasts exactly the divisor in clocks, and `tx_ready` stays low for exactly (1 + data bits + stop bits) × divisor cycles from the cycle after acceptance.
- R3: `tx_data` is captured only on a clock edge where `tx_strobe` and `tx_ready` are both high. A strobe raised while a frame is being sent changes neither that frame nor the frames that follow.
- R4: A received frame of N data bits sent least significant bit first is presented as `rx_data[N-1:0]`, with all higher bits zero.
- R5: Once `rx_valid` is high, it and `rx_data` hold their values until a cycle in which `rx_ack` is high.
- R6: The receiver passes `rxd` through a two-flop synchronizer and checks the start bit half a bit period after it first sees it low. If the line reads high at that point, the receiver returns to idle and delivers nothing.
- R7: Every stop bit is sampled at its centre. If any of them reads low, the frame is discarded without raising `rx_valid`.
- R8: If a new frame completes while `rx_valid` is high and `rx_ack` is low, the new byte is dropped, `rx_data` keeps the old byte, and `rx_overrun` is set. The flag stays set until reset.
- R9: A divisor of 0 means 288 clocks per bit. A data bit count of 0, or any count above 8, means 8 data bits. A stop bit count of 0 means 1 stop bit.
- R10: Configuration changes take effect only at the next frame. A frame in progress keeps the divisor, data bit count and stop bit count it captured at its start.
- R11: With `loopback_en` high, the receiver takes its input from the transmitter's output instead of `rxd`, so a transmitted byte comes back on `rx_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_divisor | input | 16 | Clocks per serial bit; 0 selects 288 |
| cfg_data_bits | input | 4 | Data bits per frame; 0 or above 8 selects 8 |
| cfg_stop_bits | input | 2 | Stop bits per frame; 0 selects 1 |
| loopback_en | input | 1 | Feed the transmitter output into the receiver |
| rxd | input | 1 | Serial line input, idle high |
| txd | output | 1 | Serial line output, idle high |
| tx_strobe | input | 1 | Offer `tx_data` to the transmitter |
| tx_data | input | 8 | Byte to transmit |
| tx_ready | output | 1 | Transmitter idle and able to accept a byte |
| rx_valid | output | 1 | A received byte is waiting |
| rx_data | output | 8 | Received byte, right aligned |
| rx_ack | input | 1 | Consumer has taken the waiting byte |
| rx_overrun | output | 1 | Sticky flag: a byte was lost while one was waiting |

## Verification
The bench builds the engine with its default parameters: an 8-bit data path, a 16-bit divisor and two synchronizer stages. Because the divisor is a live input, the bench can run most frames at 16 to 40 clocks per bit. That makes it cheap to cover many random frame shapes and the glitch, bad-stop and overrun cases. One frame runs at the 288-clock default to exercise the zero-selects-default path. Mid-frame divisor changes and strobes raised while the transmitter is busy are applied as directed cases.

// File: rtl/uart_engine_pkg.sv
// Shared definitions for the serial engine: default frame settings and
// the phase encoding used by both the transmit and receive sequencers.
package uart_engine_pkg;

    localparam int unsigned DEF_DIVISOR = 288;
    localparam int unsigned DEF_STOP    = 1;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_START = 2'd1,
        PH_DATA  = 2'd2,
        PH_STOP  = 2'd3
    } phase_t;

endpackage

// File: rtl/uart_line_sync.sv
// Multi-stage synchronizer for an asynchronous line input.
// Assumes the line idles high, so every stage resets to one.
module uart_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain;

    // Shift the raw line through the synchronizing flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], din};
        end
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/uart_tx_unit.sv
// Serial transmitter. It accepts a byte while idle, then sends a start bit,
// the data bits LSB first and the stop bits. Each bit lasts div_q clocks.
// Assumes the effective settings are already resolved (non-zero, in range).
// The settings are latched at acceptance and held for the whole frame.
module uart_tx_unit
    import uart_engine_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DIV_W  = 16,
    parameter int unsigned BIT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_eff,
    input  logic [BIT_W-1:0]  bits_eff,
    input  logic [1:0]        stops_eff,
    input  logic              strobe,
    input  logic [DATA_W-1:0] data,
    output logic              ready,
    output logic              txd
);

    localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);
    localparam logic [BIT_W-1:0] BIT_ONE = BIT_W'(1);

    phase_t            phase;
    logic [DIV_W-1:0]  cnt;
    logic [DIV_W-1:0]  div_q;
    logic [BIT_W-1:0]  bits_q;
    logic [BIT_W-1:0]  bit_idx;
    logic [1:0]        stops_q;
    logic [1:0]        stop_idx;
    logic [DATA_W-1:0] shreg;
    logic              bit_end;

    assign bit_end = (cnt == div_q - DIV_ONE);
    assign ready   = (phase == PH_IDLE);

    // Frame sequencer: drives the line and times every bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            txd      <= 1'b1;
            cnt      <= '0;
            div_q    <= '0;
            bits_q   <= '0;
            bit_idx  <= '0;
            stops_q  <= '0;
            stop_idx <= '0;
            shreg    <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (strobe) begin
                        div_q   <= div_eff;
                        bits_q  <= bits_eff;
                        stops_q <= stops_eff;
                        shreg   <= data;
                        cnt     <= '0;
                        txd     <= 1'b0;
                        phase   <= PH_START;
                    end
                end
                PH_START: begin
                    if (bit_end) begin
                        cnt     <= '0;
                        txd     <= shreg[0];
                        shreg   <= shreg >> 1;
                        bit_idx <= BIT_ONE;
                        phase   <= PH_DATA;
                    end else begin
                        cnt <= cnt + DIV_ONE;
                    end
                end
                PH_DATA: begin
                    if (bit_end) begin
                        cnt <= '0;
                        if (bit_idx == bits_q) begin
                            txd      <= 1'b1;
                            stop_idx <= 2'd1;
                            phase    <= PH_STOP;
                        end else begin
                            txd     <= shreg[0];
                            shreg   <= shreg >> 1;
                            bit_idx <= bit_idx + BIT_ONE;
                        end
                    end else begin
                        cnt <= cnt + DIV_ONE;
                    end
                end
                PH_STOP: begin
                    if (bit_end) begin
                        cnt <= '0;
                        if (stop_idx == stops_q) begin
                            phase <= PH_IDLE;
                        end else begin
                            stop_idx <= stop_idx + 2'd1;
                        end
                    end else begin
                        cnt <= cnt + DIV_ONE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/uart_rx_unit.sv
// Serial receiver. It works on an already synchronized line, checks the
// start bit half a bit after detection and samples the data and stop bits
// one bit period apart. It delivers a byte through a valid/ack hold
// register with a sticky overrun flag. Settings are latched at each start
// bit.
module uart_rx_unit
    import uart_engine_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DIV_W  = 16,
    parameter int unsigned BIT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line,
    input  logic [DIV_W-1:0]  div_eff,
    input  logic [BIT_W-1:0]  bits_eff,
    input  logic [1:0]        stops_eff,
    output logic              valid,
    output logic [DATA_W-1:0] data,
    input  logic              ack,
    output logic              overrun
);

    localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);
    localparam logic [BIT_W-1:0] BIT_ONE = BIT_W'(1);

    phase_t            phase;
    logic [DIV_W-1:0]  cnt;
    logic [DIV_W-1:0]  div_q;
    logic [BIT_W-1:0]  bits_q;
    logic [BIT_W-1:0]  bit_idx;
    logic [1:0]        stops_q;
    logic [1:0]        stop_idx;
    logic              stop_bad;
    logic [DATA_W-1:0] shreg;
    logic              bit_end;
    logic              frame_done;
    logic              frame_good;
    logic [DATA_W-1:0] assembled;

    assign bit_end    = (cnt == div_q - DIV_ONE);
    assign frame_done = (phase == PH_STOP) && bit_end && (stop_idx == stops_q);
    assign frame_good = frame_done && line && !stop_bad;
    assign assembled  = shreg >> (DATA_W - int'(bits_q));

    // Frame sequencer: start validation, data shifting, stop checking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            div_q    <= '0;
            bits_q   <= '0;
            bit_idx  <= '0;
            stops_q  <= '0;
            stop_idx <= '0;
            stop_bad <= 1'b0;
            shreg    <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (!line) begin
                        div_q   <= div_eff;
                        bits_q  <= bits_eff;
                        stops_q <= stops_eff;
                        cnt     <= '0;
                        phase   <= PH_START;
                    end
                end
                PH_START: begin
                    if (cnt == (div_q >> 1)) begin
                        cnt     <= '0;
                        bit_idx <= '0;
                        phase   <= line ? PH_IDLE : PH_DATA;
                    end else begin
                        cnt <= cnt + DIV_ONE;
                    end
                end
                PH_DATA: begin
                    if (bit_end) begin
                        cnt   <= '0;
                        shreg <= {line, shreg[DATA_W-1:1]};
                        if (bit_idx == bits_q - BIT_ONE) begin
                            stop_idx <= 2'd1;
                            stop_bad <= 1'b0;
                            phase    <= PH_STOP;
                        end else begin
                            bit_idx <= bit_idx + BIT_ONE;
                        end
                    end else begin
                        cnt <= cnt + DIV_ONE;
                    end
                end
                PH_STOP: begin
                    if (bit_end) begin
                        cnt <= '0;
                        if (stop_idx == stops_q) begin
                            phase <= PH_IDLE;
                        end else begin
                            stop_bad <= stop_bad | !line;
                            stop_idx <= stop_idx + 2'd1;
                        end
                    end else begin
                        cnt <= cnt + DIV_ONE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Delivery register: hold the byte until ack, flag any byte lost meanwhile.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid   <= 1'b0;
            data    <= '0;
            overrun <= 1'b0;
        end else begin
            if (valid && ack) begin
                valid <= 1'b0;
            end
            if (frame_good) begin
                if (valid && !ack) begin
                    overrun <= 1'b1;
                end else begin
                    data  <= assembled;
                    valid <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/uart_engine.sv
// Top of the serial engine. It resolves zero or out-of-range settings to
// their defaults, selects the receiver source (line or loopback) and joins
// the transmitter, synchronizer and receiver. Assumes rxd is asynchronous
// to clk and idles high.
module uart_engine
    import uart_engine_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned DIV_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  cfg_divisor,
    input  logic [3:0]        cfg_data_bits,
    input  logic [1:0]        cfg_stop_bits,
    input  logic              loopback_en,
    input  logic              rxd,
    output logic              txd,
    input  logic              tx_strobe,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_ready,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    input  logic              rx_ack,
    output logic              rx_overrun
);

    localparam int unsigned BIT_W = $clog2(DATA_W + 1);

    logic [DIV_W-1:0] div_eff;
    logic [BIT_W-1:0] bits_eff;
    logic [1:0]       stops_eff;
    logic             tx_line;
    logic             rx_raw;
    logic             rx_line;

    // Map zero or over-range settings onto the defaults.
    always_comb begin
        div_eff   = (cfg_divisor == '0) ? DIV_W'(DEF_DIVISOR) : cfg_divisor;
        bits_eff  = ((cfg_data_bits == 4'd0) || (int'(cfg_data_bits) > DATA_W))
                    ? BIT_W'(DATA_W) : BIT_W'(cfg_data_bits);
        stops_eff = (cfg_stop_bits == 2'd0) ? 2'(DEF_STOP) : cfg_stop_bits;
    end

    assign txd    = tx_line;
    assign rx_raw = loopback_en ? tx_line : rxd;

    uart_tx_unit #(.DATA_W(DATA_W), .DIV_W(DIV_W), .BIT_W(BIT_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_eff   (div_eff),
        .bits_eff  (bits_eff),
        .stops_eff (stops_eff),
        .strobe    (tx_strobe),
        .data      (tx_data),
        .ready     (tx_ready),
        .txd       (tx_line)
    );

    uart_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rx_raw),
        .dout  (rx_line)
    );

    uart_rx_unit #(.DATA_W(DATA_W), .DIV_W(DIV_W), .BIT_W(BIT_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .line      (rx_line),
        .div_eff   (div_eff),
        .bits_eff  (bits_eff),
        .stops_eff (stops_eff),
        .valid     (rx_valid),
        .data      (rx_data),
        .ack       (rx_ack),
        .overrun   (rx_overrun)
    );

endmodule

// File: rtl/uart_engine_checker.sv
// Port-level temporal checks for the serial engine, bound to every instance.
module uart_engine_checker #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              txd,
    input logic              tx_strobe,
    input logic              tx_ready,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_ack,
    input logic              rx_overrun
);

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (txd && tx_ready && !rx_valid && !rx_overrun)); // R1

    AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> txd); // R2

    AST_TX_ACCEPT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_strobe && tx_ready) |=> (!tx_ready && !txd)); // R3

    AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ack) |=> (rx_valid && $stable(rx_data))); // R5

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |=> rx_overrun); // R8

endmodule

bind uart_engine uart_engine_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .txd        (txd),
    .tx_strobe  (tx_strobe),
    .tx_ready   (tx_ready),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .rx_ack     (rx_ack),
    .rx_overrun (rx_overrun)
);

// File: tb/uart_engine_test.sv
`timescale 1ns/1ps
module uart_engine_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_divisor = 16'd16;
    logic [3:0]  cfg_data_bits = 4'd8;
    logic [1:0]  cfg_stop_bits = 2'd1;
    logic        loopback_en = 1'b0;
    logic        rxd = 1'b1;
    logic        txd;
    logic        tx_strobe = 1'b0;
    logic [7:0]  tx_data = 8'h00;
    logic        tx_ready;
    logic        rx_valid;
    logic [7:0]  rx_data;
    logic        rx_ack = 1'b0;
    logic        rx_overrun;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic samp [0:4095];

    always #2 clk = ~clk;

    uart_engine uut (
        .clk(clk), .rst_n(rst_n), .cfg_divisor(cfg_divisor),
        .cfg_data_bits(cfg_data_bits), .cfg_stop_bits(cfg_stop_bits),
        .loopback_en(loopback_en), .rxd(rxd), .txd(txd),
        .tx_strobe(tx_strobe), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ack(rx_ack),
        .rx_overrun(rx_overrun)
    );

    function automatic int eff_div(input logic [15:0] c);
        return (c == 0) ? 288 : int'(c);
    endfunction
    function automatic int eff_bits(input logic [3:0] c);
        return (c == 0 || c > 8) ? 8 : int'(c);
    endfunction
    function automatic int eff_stop(input logic [1:0] c);
        return (c == 0) ? 1 : int'(c);
    endfunction
    function automatic logic [7:0] keep_low(input logic [7:0] d, input int n);
        return d & 8'((1 << n) - 1);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Send one byte; optionally poke a busy strobe or change the divisor mid-frame.
    task automatic tx_send(input logic [7:0] d, input bit poke_busy,
                           input logic [15:0] new_div, input string req);
        int dv = eff_div(cfg_divisor);
        int nb = eff_bits(cfg_data_bits);
        int ns = eff_stop(cfg_stop_bits);
        int len = (1 + nb + ns) * dv;
        int n = 0;
        int bad = 0;
        @(negedge clk);
        tx_strobe = 1'b1;
        tx_data = d;
        @(negedge clk);
        tx_strobe = 1'b0;
        while (!tx_ready && n < 4000) begin
            samp[n] = txd;
            if (poke_busy) begin
                tx_strobe = (n == 2 * dv);
                tx_data = ~d;
            end
            if (new_div != 0 && n == dv) cfg_divisor = new_div;
            n++;
            @(negedge clk);
        end
        tx_strobe = 1'b0;
        check(n == len, {req, " frame length"}, n, len);
        for (int k = 0; k < 1 + nb + ns; k++) begin
            logic e;
            e = (k == 0) ? 1'b0 : (k <= nb) ? d[k-1] : 1'b1;
            if (k * dv + dv / 2 < n && samp[k * dv + dv / 2] !== e) bad++;
        end
        check(bad == 0, {req, " frame bits"}, bad, 0);
    endtask

    // Drive one frame onto rxd using the current settings.
    task automatic rx_send(input logic [7:0] d, input bit stop_ok);
        int dv = eff_div(cfg_divisor);
        int nb = eff_bits(cfg_data_bits);
        int ns = eff_stop(cfg_stop_bits);
        @(negedge clk);
        rxd = 1'b0;
        repeat (dv) @(negedge clk);
        for (int k = 0; k < nb; k++) begin
            rxd = d[k];
            repeat (dv) @(negedge clk);
        end
        for (int k = 0; k < ns; k++) begin
            rxd = (k == ns - 1) ? stop_ok : 1'b1;
            repeat (dv) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (dv) @(negedge clk);
    endtask

    task automatic take_byte();
        @(negedge clk);
        rx_ack = 1'b1;
        @(negedge clk);
        rx_ack = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed = 20240611;
        void'($urandom(seed));
        repeat (4) @(negedge clk);
        check(txd === 1'b1 && tx_ready === 1'b1, "R1 tx reset", int'(txd), 1);
        check(rx_valid === 1'b0 && rx_overrun === 1'b0, "R1 rx reset", int'(rx_valid), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Random transmit and receive frames (R2, R4).
        for (int i = 0; i < 10; i++) begin
            logic [7:0] d;
            d = 8'($urandom);
            cfg_divisor = 16'(16 + $urandom % 25);
            cfg_data_bits = 4'(5 + $urandom % 4);
            cfg_stop_bits = 2'(1 + $urandom % 2);
            tx_send(d, 1'b0, 16'd0, "R2");
            rx_send(d, 1'b1);
            check(rx_valid === 1'b1, "R4 valid", int'(rx_valid), 1);
            check(rx_data === keep_low(d, eff_bits(cfg_data_bits)), "R4 data",
                  int'(rx_data), int'(keep_low(d, eff_bits(cfg_data_bits))));
            repeat (5) @(negedge clk);
            check(rx_valid === 1'b1 && rx_data === keep_low(d, eff_bits(cfg_data_bits)),
                  "R5 held until ack", int'(rx_data), int'(keep_low(d, eff_bits(cfg_data_bits))));
            take_byte();
            check(rx_valid === 1'b0, "R5 ack clears", int'(rx_valid), 0);
        end

        // Busy strobe ignored (R3).
        cfg_divisor = 16'd20; cfg_data_bits = 4'd8; cfg_stop_bits = 2'd1;
        tx_send(8'hA5, 1'b1, 16'd0, "R3");
        repeat (3) @(negedge clk);
        check(tx_ready === 1'b1 && txd === 1'b1, "R3 no extra frame", int'(tx_ready), 1);

        // Divisor change mid-frame (R10).
        tx_send(8'h3C, 1'b0, 16'd33, "R10");
        cfg_divisor = 16'd20;

        // Glitch rejection (R6).
        @(negedge clk); rxd = 1'b0;
        repeat (3) @(negedge clk); rxd = 1'b1;
        repeat (300) @(negedge clk);
        check(rx_valid === 1'b0, "R6 glitch dropped", int'(rx_valid), 0);
        rx_send(8'h96, 1'b1);
        check(rx_valid === 1'b1 && rx_data === 8'h96, "R6 recovery", int'(rx_data), 8'h96);
        take_byte();

        // Bad stop bit (R7).
        cfg_stop_bits = 2'd2;
        rx_send(8'h5A, 1'b0);
        repeat (2 * 20) @(negedge clk);
        check(rx_valid === 1'b0, "R7 bad stop discarded", int'(rx_valid), 0);
        cfg_stop_bits = 2'd1;
        rx_send(8'h69, 1'b1);
        check(rx_valid === 1'b1 && rx_data === 8'h69, "R7 recovery", int'(rx_data), 8'h69);
        check(rx_overrun === 1'b0, "R8 no overrun yet", int'(rx_overrun), 0);

        // Overrun (R8): second byte arrives while first is still waiting.
        rx_send(8'hC3, 1'b1);
        check(rx_data === 8'h69 && rx_valid === 1'b1, "R8 old byte kept", int'(rx_data), 8'h69);
        check(rx_overrun === 1'b1, "R8 overrun set", int'(rx_overrun), 1);
        take_byte();
        repeat (4) @(negedge clk);
        check(rx_overrun === 1'b1, "R8 overrun sticky", int'(rx_overrun), 1);

        // Clamp of an over-range data bit count (R9).
        cfg_data_bits = 4'd12; cfg_stop_bits = 2'd2;
        tx_send(8'hE7, 1'b0, 16'd0, "R9 clamp");

        // Loopback (R11): external rxd held low must not matter.
        cfg_data_bits = 4'd7; cfg_stop_bits = 2'd1; cfg_divisor = 16'd24;
        loopback_en = 1'b1; rxd = 1'b0;
        tx_send(8'hD5, 1'b0, 16'd0, "R11");
        repeat (4) @(negedge clk);
        check(rx_valid === 1'b1 && rx_data === 8'h55, "R11 loopback byte", int'(rx_data), 8'h55);
        take_byte();
        rxd = 1'b1;
        repeat (4) @(negedge clk);
        loopback_en = 1'b0;

        // All-zero settings select the defaults (R9).
        cfg_divisor = 16'd0; cfg_data_bits = 4'd0; cfg_stop_bits = 2'd0;
        tx_send(8'h81, 1'b0, 16'd0, "R9 defaults");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule